// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Buffer

This block sits between an instruction memory that returns aligned 32-bit words and an instruction decoder that consumes instructions of one to three bytes. It fetches words in address order into an eight-byte circular store. A byte-select stage picks out the opcode and the two bytes that follow it, starting at the current read position. An instruction that begins in one word and ends in the next is therefore handed to the decoder whole.

The decoder reports the length of the instruction it sees on `ins_len_i`. When it consumes that instruction, the read position moves forward by that length. A redirect throws away everything held and restarts fetching at the word that contains the target. The bytes of that first word that lie before the target are skipped.

Top module: `prefetch_buf`

## Requirements
- R1: After reset, `ins_valid_o` is low, `mem_req_o` is high and `mem_addr_o` equals `RESET_ADDR` (default 0).
- R2: `mem_req_o` is high only when at most 4 unconsumed bytes are held and `redirect_i` is low. A word is accepted on a clock edge where `mem_req_o` and `mem_valid_i` are both high. `mem_addr_o` rises by 4 after each accepted word and is otherwise held. With nothing consumed, the store fills to 8 bytes and requesting stops.
- R3: In a memory word, the byte at address A+k lies in bits [8k+7:8k] (little-endian, where A is the word address).
- R4: `ins_op_o`, `ins_arg1_o` and `ins_arg2_o` are the bytes at the current instruction address, at that address plus 1 and at that address plus 2. `ins_valid_o` is high when at least as many bytes are held as the length on `ins_len_i`. The value 0 on `ins_len_i` is treated as 1.
- R5: An instruction whose bytes span two memory words is presented complete, with its bytes drawn from both words.
- R6: On a clock edge with `consume_i` and `ins_valid_o` both high, the instruction address advances by the length. `consume_i` while `ins_valid_o` is low has no effect.
- R7: On a redirect, the buffer is emptied: `ins_valid_o` is low in the next cycle, and `mem_addr_o` becomes the target with its two low bits cleared. A memory word and a consume in the same cycle as the redirect are dropped.
- R8: After a redirect, the first byte presented is the byte at the target address. A 3-byte target instruction that straddles a word boundary becomes valid one cycle later than an aligned one, after the second word has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | AW | Word-aligned fetch address |
| mem_data_i | input | 32 | Memory word, little-endian |
| mem_valid_i | input | 1 | Memory word is valid this cycle |
| redirect_i | input | 1 | Flush the buffer and refetch from the target |
| redirect_addr_i | input | AW | Redirect target byte address |
| ins_len_i | input | 2 | Length of the presented instruction, from decode |
| consume_i | input | 1 | Decoder takes the presented instruction |
| ins_valid_o | output | 1 | Presented instruction is complete |
| ins_op_o | output | 8 | Opcode byte |
| ins_arg1_o | output | 8 | First operand byte |
| ins_arg2_o | output | 8 | Second operand byte |

## Verification
A table of instruction lengths, redirect targets and memory-stall settings is walked against a memory whose byte values are computed from the address. The mixed lengths move the read position through every byte offset and across the ring wrap. Redirects to targets at offsets 1, 2 and 3 exercise the skipping of leading bytes and the assembly of instructions that straddle a word boundary. Directed cases then compare a straddling target with an aligned one to expose the one extra cycle, and they separate a consume that is ignored from one that advances the read position. Further cases hold a stalled memory and confirm that a full store stops requesting.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BUF_WORDS  = 2;
  localparam int unsigned BUF_BYTES  = WORD_BYTES * BUF_WORDS;
  localparam int unsigned PTR_W      = $clog2(BUF_BYTES);
  localparam int unsigned CNT_W      = PTR_W + 1;
  localparam int unsigned SLOT_W     = $clog2(BUF_WORDS);
  localparam int unsigned MAX_LEN    = 3;

  typedef logic [7:0]        byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // length 0 from decode is taken as 1
  function automatic logic [1:0] norm_len(logic [1:0] l);
    return (l == 2'd0) ? 2'd1 : l;
  endfunction
endpackage

// File: rtl/pfb_fill_ctrl.sv
module pfb_fill_ctrl
  import pfb_pkg::*;
#(
  parameter int unsigned    AW         = 16,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mem_valid_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          take_i,
  input  logic [1:0]    take_len_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          wr_en_o,
  output slot_t         wr_slot_o,
  output ptr_t          rd_ptr_o,
  output cnt_t          count_o
);
  localparam cnt_t FREE_LIMIT = cnt_t'(BUF_BYTES - WORD_BYTES);

  logic [AW-1:0] fetch_q;
  cnt_t          cnt_q, add_b, sub_b;
  ptr_t          rd_q;
  slot_t         slot_q;
  logic [1:0]    skip_q;
  logic          accept;

  assign mem_req_o = !redirect_i && (cnt_q <= FREE_LIMIT);
  assign accept    = mem_req_o && mem_valid_i;

  always_comb begin
    add_b = accept ? cnt_t'(WORD_BYTES - int'(skip_q)) : '0;
    sub_b = take_i ? cnt_t'(take_len_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= {RESET_ADDR[AW-1:2], 2'b00};
      cnt_q   <= '0;
      rd_q    <= ptr_t'(RESET_ADDR[1:0]);
      slot_q  <= '0;
      skip_q  <= RESET_ADDR[1:0];
    end else if (redirect_i) begin
      fetch_q <= {redirect_addr_i[AW-1:2], 2'b00};
      cnt_q   <= '0;
      rd_q    <= ptr_t'(redirect_addr_i[1:0]);
      slot_q  <= '0;
      skip_q  <= redirect_addr_i[1:0];
    end else begin
      cnt_q <= cnt_q + add_b - sub_b;
      if (take_i) rd_q <= rd_q + ptr_t'(take_len_i);
      if (accept) begin
        fetch_q <= fetch_q + AW'(WORD_BYTES);
        slot_q  <= slot_q + 1'b1;
        skip_q  <= '0;
      end
    end
  end

  assign mem_addr_o = fetch_q;
  assign wr_en_o    = accept;
  assign wr_slot_o  = slot_q;
  assign rd_ptr_o   = rd_q;
  assign count_o    = cnt_q;

  // R2
  occupancy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cnt_t'(BUF_BYTES));
  // R2
  fetch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (fetch_q == $past(fetch_q) + AW'(WORD_BYTES)));
  // R7
  redirect_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (fetch_q == {$past(redirect_addr_i[AW-1:2]), 2'b00}));
endmodule

// File: rtl/pfb_byte_store.sv
module pfb_byte_store
  import pfb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  slot_t                   wr_slot_i,
  input  logic [8*WORD_BYTES-1:0] wr_data_i,
  output byte_t [BUF_BYTES-1:0]   bytes_o
);
  byte_t [BUF_BYTES-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < WORD_BYTES; w++)
        store_q[int'(wr_slot_i) * WORD_BYTES + w] <= wr_data_i[8*w +: 8];
    end
  end

  assign bytes_o = store_q;
endmodule

// File: rtl/pfb_byte_sel.sv
module pfb_byte_sel
  import pfb_pkg::*;
(
  input  byte_t [BUF_BYTES-1:0] bytes_i,
  input  ptr_t                  rd_ptr_i,
  output byte_t [MAX_LEN-1:0]   sel_o
);
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_sel
    ptr_t idx;
    assign idx      = rd_ptr_i + ptr_t'(k);  // wraps around the ring
    assign sel_o[k] = bytes_i[idx];
  end
endmodule

// File: rtl/prefetch_buf.sv
module prefetch_buf
  import pfb_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_data_i,
  input  logic          mem_valid_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic [1:0]    ins_len_i,
  input  logic          consume_i,
  output logic          ins_valid_o,
  output logic [7:0]    ins_op_o,
  output logic [7:0]    ins_arg1_o,
  output logic [7:0]    ins_arg2_o
);
  logic [1:0]            len_eff;
  logic                  take, wr_en;
  slot_t                 wr_slot;
  ptr_t                  rd_ptr;
  cnt_t                  count;
  byte_t [BUF_BYTES-1:0] bytes;
  byte_t [MAX_LEN-1:0]   sel;

  assign len_eff     = norm_len(ins_len_i);
  assign ins_valid_o = count >= cnt_t'(len_eff);
  assign take        = consume_i && ins_valid_o && !redirect_i;

  pfb_fill_ctrl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk_i, .rst_ni, .mem_valid_i, .redirect_i, .redirect_addr_i,
    .take_i(take), .take_len_i(len_eff),
    .mem_req_o, .mem_addr_o,
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .rd_ptr_o(rd_ptr), .count_o(count)
  );

  pfb_byte_store u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_slot_i(wr_slot),
    .wr_data_i(mem_data_i), .bytes_o(bytes)
  );

  pfb_byte_sel u_sel (.bytes_i(bytes), .rd_ptr_i(rd_ptr), .sel_o(sel));

  assign ins_op_o   = sel[0];
  assign ins_arg1_o = sel[1];
  assign ins_arg2_o = sel[2];

  // R7
  redirect_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !ins_valid_o);
  // R6
  idle_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !ins_valid_o && !redirect_i) |=> $stable(rd_ptr));
endmodule

// File: tb/prefetch_buf_tb_top.sv
module prefetch_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_valid, redirect, consume, ins_valid;
  logic [15:0] mem_addr, redirect_addr;
  logic [31:0] mem_data;
  logic [1:0]  ins_len;
  logic [7:0]  op, a1, a2;
  logic        stall_mode = 1'b0, mem_hold = 1'b0;
  logic [31:0] cyc = '0;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] pc;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mb(logic [15:0] x);
    return x[7:0] ^ x[15:8] ^ 8'ha5;
  endfunction

  assign mem_data  = {mb(mem_addr + 16'd3), mb(mem_addr + 16'd2), mb(mem_addr + 16'd1), mb(mem_addr)};
  assign mem_valid = !mem_hold && (!stall_mode || cyc[1:0] != 2'b01);

  prefetch_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .mem_valid_i(mem_valid), .redirect_i(redirect),
    .redirect_addr_i(redirect_addr), .ins_len_i(ins_len), .consume_i(consume),
    .ins_valid_o(ins_valid), .ins_op_o(op), .ins_arg1_o(a1), .ins_arg2_o(a2)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_bytes(logic [15:0] a, logic [1:0] l);
    logic [23:0] m;
    m = (l == 2'd3) ? 24'hffffff : (l == 2'd2) ? 24'h00ffff : 24'h0000ff;
    return {mb(a + 16'd2), mb(a + 16'd1), mb(a)} & m;
  endfunction

  // R4 R5 R6: wait for a valid instruction, check it, consume it
  task automatic do_insn(input logic [1:0] l);
    logic [23:0] m;
    @(negedge clk);
    ins_len = l; consume = 1'b1;
    #1;
    while (!ins_valid) begin @(negedge clk); #1; end
    m = (l == 2'd3) ? 24'hffffff : (l == 2'd2) ? 24'h00ffff : 24'h0000ff;
    chk(({a2, a1, op} & m) == exp_bytes(pc, l), "R4/R5 instruction bytes",
        {8'h0, {a2, a1, op} & m}, {8'h0, exp_bytes(pc, l)});
    @(posedge clk); #1;
    consume = 1'b0;
    pc = pc + 16'(l);
  endtask

  // R7
  task automatic do_redirect(input logic [15:0] t);
    @(negedge clk);
    consume = 1'b0; redirect = 1'b1; redirect_addr = t;
    @(posedge clk); #1;
    redirect = 1'b0;
    pc = t;
    chk(!ins_valid, "R7 valid low after redirect", {31'h0, ins_valid}, 32'h0);
    chk(mem_addr == {t[15:2], 2'b00}, "R7 refetch address", {16'h0, mem_addr}, {16'h0, t[15:2], 2'b00});
  endtask

  // {redirect, stall, target, length}
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000, 2'd3}, {1'b0, 1'b0, 16'h0000, 2'd1},
    {1'b0, 1'b0, 16'h0000, 2'd2}, {1'b0, 1'b0, 16'h0000, 2'd3},
    {1'b0, 1'b0, 16'h0000, 2'd3}, {1'b0, 1'b0, 16'h0000, 2'd1},
    {1'b0, 1'b0, 16'h0000, 2'd2}, {1'b1, 1'b0, 16'h1233, 2'd3},
    {1'b0, 1'b0, 16'h0000, 2'd2}, {1'b0, 1'b0, 16'h0000, 2'd1},
    {1'b1, 1'b1, 16'h40fe, 2'd2}, {1'b0, 1'b1, 16'h0000, 2'd3},
    {1'b0, 1'b1, 16'h0000, 2'd1}, {1'b0, 1'b1, 16'h0000, 2'd3},
    {1'b1, 1'b1, 16'h2001, 2'd1}, {1'b0, 1'b1, 16'h0000, 2'd3},
    {1'b0, 1'b0, 16'h0000, 2'd2}, {1'b0, 1'b0, 16'h0000, 2'd0}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    redirect = 1'b0; redirect_addr = '0; consume = 1'b0; ins_len = 2'd3;
    pc = '0;
    #35;
    // R1
    chk(!ins_valid, "R1 reset valid", {31'h0, ins_valid}, 32'h0);
    chk(mem_req, "R1 reset request", {31'h0, mem_req}, 32'h1);
    chk(mem_addr == 16'h0, "R1 reset address", {16'h0, mem_addr}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: store full, no consume
    chk(!mem_req, "R2 request stops when full", {31'h0, mem_req}, 32'h0);
    chk(mem_addr == 16'h8, "R2 address after two words", {16'h0, mem_addr}, 32'h8);
    // R3
    chk({a2, a1, op} == {mb(16'd2), mb(16'd1), mb(16'd0)}, "R3 byte order",
        {8'h0, a2, a1, op}, {8'h0, mb(16'd2), mb(16'd1), mb(16'd0)});

    for (int i = 0; i < NV; i++) begin
      stall_mode = VEC[i][18];
      if (VEC[i][19]) do_redirect(VEC[i][17:2]);
      do_insn(VEC[i][1:0] == 2'd0 ? 2'd1 : VEC[i][1:0]);
    end
    stall_mode = 1'b0;

    // R8: straddling target at offset 3
    do_redirect(16'h3007);
    ins_len = 2'd1; #1;
    @(posedge clk); #1;
    chk(ins_valid, "R8 one byte after first word", {31'h0, ins_valid}, 32'h1);
    chk(op == mb(16'h3007), "R8 first byte is target", {24'h0, op}, {24'h0, mb(16'h3007)});
    ins_len = 2'd3; consume = 1'b1; #1;
    chk(!ins_valid, "R8 straddler not yet valid", {31'h0, ins_valid}, 32'h0);
    @(posedge clk); #1;
    consume = 1'b0; #1;
    chk(ins_valid, "R8 straddler valid after second word", {31'h0, ins_valid}, 32'h1);
    // R6: earlier consume while invalid had no effect
    chk(op == mb(16'h3007), "R6 idle consume ignored", {24'h0, op}, {24'h0, mb(16'h3007)});
    chk({a2, a1} == {mb(16'h3009), mb(16'h3008)}, "R5 bytes from two words",
        {16'h0, a2, a1}, {16'h0, mb(16'h3009), mb(16'h3008)});

    // R8: aligned target valid one cycle sooner
    do_redirect(16'h3008);
    ins_len = 2'd3;
    @(posedge clk); #1;
    chk(ins_valid, "R8 aligned target valid", {31'h0, ins_valid}, 32'h1);

    // R2: memory stall holds the address
    mem_hold = 1'b1;
    do_redirect(16'h5002);
    repeat (3) @(posedge clk);
    #1;
    chk(mem_addr == 16'h5000, "R2 address held on stall", {16'h0, mem_addr}, 32'h5000);
    ins_len = 2'd0; #1;
    chk(!ins_valid, "R4 empty store invalid", {31'h0, ins_valid}, 32'h0);
    mem_hold = 1'b0;
    @(posedge clk); #1;
    chk(ins_valid && op == mb(16'h5002), "R4 length 0 taken as 1",
        {23'h0, ins_valid, op}, {23'h0, 1'b1, mb(16'h5002)});

    finish_run();
  end
endmodule